// File: doc/BRIEF.md
# Two-Ball Shared Drawer Controller

This block paints two small balls into a 320x240 bitmap frame buffer, and it has only one ball sequencer to do it with. The sequencer emits one pixel coordinate per clock after a start request. The controller decides which ball the sequencer serves at any moment. It gives the sequencer the origin of that ball and tags each pixel with the ball's 3-bit colour, one bit per primary: bit 2 red, bit 1 green, bit 0 blue. It forwards the pixel stream to the frame buffer write port.

Each ball is five pixels in a plus shape, three pixels wide and three tall. The origin is the leftmost column and the top row. Pixels come out in row-major order: (x+1,y), (x,y+1), (x+1,y+1), (x+2,y+1), (x+1,y+2). The first ball sits at (100,50) in red (3'b100). The second sits at (200,150) in green plus blue (3'b011). After reset the controller draws the first ball to completion, drops the start request to re-arm the sequencer, draws the second ball, and then goes quiet until the next reset.

Controller states: `ST_BOOT` (reset state, start low) → `ST_ARM0` (start high, origin 0) → `ST_DRAW0` (start held, wait for done) → `ST_GAP` (start low so the sequencer re-arms) → `ST_ARM1` → `ST_DRAW1` → `ST_END` (terminal, start low). Sequencer states: `SQ_IDLE` → `SQ_PIX` (one pixel per cycle, done on the last one) → `SQ_HOLD` (wait for start low) → `SQ_IDLE`.

Top module: `mdc_draw_top`

## Requirements
- R1: While reset is high, and in the cycle after it is released, vga_wr_en is 0 and vga_color is 3'b000.
- R2: The first ball is written as five pixels at origin (100,50) in the row-major plus order given above, each with vga_color 3'b100.
- R3: The second ball is written only after all five pixels of the first. It uses origin (200,150), the same pixel order, and vga_color 3'b011.
- R4: Each ball is written in five consecutive cycles with vga_wr_en high, one pixel per cycle.
- R5: Between the two balls vga_wr_en is low for at least one cycle, so exactly two separate write bursts occur.
- R6: After the second ball, vga_wr_en stays low and no further pixel is written until reset.
- R7: A reset asserted in the middle of a ball discards the partial sequence. After release, drawing restarts with the first ball.
- R8: Whenever vga_wr_en is high, vga_color is nonzero. Whenever it is low, vga_color is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vga_x | output | 9 | Frame buffer x coordinate |
| vga_y | output | 8 | Frame buffer y coordinate |
| vga_color | output | 3 | Pixel colour, bit 2 red, bit 1 green, bit 0 blue |
| vga_wr_en | output | 1 | Frame buffer write enable |

## Verification
The main pattern is a clean reset followed by a full run. Every written pixel is compared in order against a model of both balls. A wrong origin or colour multiplexer is caught this way, and so is a missing re-arm gap, which would merge the bursts. A long quiet window after the second ball separates a true terminal state from a controller that loops back and redraws. A second reset asserted partway through the first ball shows whether the sequence restarts cleanly. The alternative is leaking pixels from the abandoned ball or resuming with the second one.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

    localparam int BALL_PIXELS = 5;
    localparam int BALL_IDX_W  = $clog2(BALL_PIXELS);

    // Plus-shaped ball, row-major: column offset of pixel idx
    function automatic logic [1:0] ball_dx(input logic [BALL_IDX_W-1:0] idx);
        logic [1:0] d;
        unique case (idx)
            3'd1:    d = 2'd0;
            3'd3:    d = 2'd2;
            default: d = 2'd1;
        endcase
        return d;
    endfunction

    // Row offset of pixel idx
    function automatic logic [1:0] ball_dy(input logic [BALL_IDX_W-1:0] idx);
        logic [1:0] d;
        unique case (idx)
            3'd0:    d = 2'd0;
            3'd4:    d = 2'd2;
            default: d = 2'd1;
        endcase
        return d;
    endfunction

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PIX,
        SQ_HOLD
    } seq_state_t;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_ARM0,
        ST_DRAW0,
        ST_GAP,
        ST_ARM1,
        ST_DRAW1,
        ST_END
    } ctl_state_t;

endpackage

// File: rtl/mdc_ball_seq.sv
module mdc_ball_seq
    import mdc_pkg::*;
#(
    parameter int X_W = 9,
    parameter int Y_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [X_W-1:0] org_x,
    input  logic [Y_W-1:0] org_y,
    output logic           draw,
    output logic           done,
    output logic [X_W-1:0] px,
    output logic [Y_W-1:0] py
);

    localparam logic [BALL_IDX_W-1:0] LAST_IDX = BALL_IDX_W'(BALL_PIXELS - 1);

    seq_state_t            state_q, state_d;
    logic [BALL_IDX_W-1:0] idx_q, idx_d;
    logic [X_W-1:0]        base_x_q, base_x_d;
    logic [Y_W-1:0]        base_y_q, base_y_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            idx_q    <= '0;
            base_x_q <= '0;
            base_y_q <= '0;
        end else begin
            state_q  <= state_d;
            idx_q    <= idx_d;
            base_x_q <= base_x_d;
            base_y_q <= base_y_d;
        end
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        base_x_d = base_x_q;
        base_y_d = base_y_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (start) begin
                    state_d  = SQ_PIX;
                    idx_d    = '0;
                    base_x_d = org_x;
                    base_y_d = org_y;
                end
            end
            SQ_PIX: begin
                if (idx_q == LAST_IDX) begin
                    idx_d   = '0;
                    state_d = start ? SQ_HOLD : SQ_IDLE;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            SQ_HOLD: begin
                if (!start) state_d = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        draw = (state_q == SQ_PIX);
        done = draw && (idx_q == LAST_IDX);
        px   = base_x_q + X_W'(ball_dx(idx_q));
        py   = base_y_q + Y_W'(ball_dy(idx_q));
    end

    // R4: a burst continues until its last pixel
    a_r4_burst_runs: assert property (@(posedge clk) disable iff (rst)
        (draw && !done) |=> draw);

    // R5: the pixel after done is never drawn in the next cycle
    a_r5_rearm_gap: assert property (@(posedge clk) disable iff (rst)
        done |=> !draw);

    // R5: a new burst needs a start seen while idle
    a_r5_start_needed: assert property (@(posedge clk) disable iff (rst)
        $rose(draw) |-> $past(start));

endmodule

// File: rtl/mdc_obj_select.sv
module mdc_obj_select #(
    parameter int             X_W    = 9,
    parameter int             Y_W    = 8,
    parameter int             C_W    = 3,
    parameter logic [X_W-1:0] X0     = 9'd100,
    parameter logic [Y_W-1:0] Y0     = 8'd50,
    parameter logic [C_W-1:0] COLOR0 = 3'b100,
    parameter logic [X_W-1:0] X1     = 9'd200,
    parameter logic [Y_W-1:0] Y1     = 8'd150,
    parameter logic [C_W-1:0] COLOR1 = 3'b011
) (
    input  logic           sel,
    output logic [X_W-1:0] org_x,
    output logic [Y_W-1:0] org_y,
    output logic [C_W-1:0] color
);

    always_comb begin
        if (sel) begin
            org_x = X1;
            org_y = Y1;
            color = COLOR1;
        end else begin
            org_x = X0;
            org_y = Y0;
            color = COLOR0;
        end
    end

endmodule

// File: rtl/mdc_ctrl.sv
module mdc_ctrl
    import mdc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic seq_done,
    output logic seq_start,
    output logic obj_sel,
    output logic drawing,
    output logic finished
);

    ctl_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_BOOT;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = ST_ARM0;
            ST_ARM0:  state_d = ST_DRAW0;
            ST_DRAW0: if (seq_done) state_d = ST_GAP;
            ST_GAP:   state_d = ST_ARM1;
            ST_ARM1:  state_d = ST_DRAW1;
            ST_DRAW1: if (seq_done) state_d = ST_END;
            ST_END:   state_d = ST_END;
            default:  state_d = ST_BOOT;
        endcase
    end

    // Outputs
    always_comb begin
        seq_start = 1'b0;
        obj_sel   = 1'b0;
        drawing   = 1'b0;
        finished  = 1'b0;
        unique case (state_q)
            ST_BOOT:  ;
            ST_ARM0:  seq_start = 1'b1;
            ST_DRAW0: begin seq_start = 1'b1; drawing = 1'b1; end
            ST_GAP:   obj_sel = 1'b1;
            ST_ARM1:  begin seq_start = 1'b1; obj_sel = 1'b1; end
            ST_DRAW1: begin seq_start = 1'b1; obj_sel = 1'b1; drawing = 1'b1; end
            ST_END:   begin obj_sel = 1'b1; finished = 1'b1; end
            default:  ;
        endcase
    end

    // R6: the terminal state is never left without reset
    a_r6_end_sticky: assert property (@(posedge clk) disable iff (rst)
        finished |=> finished);

    // R3: the second object is selected only after a done pulse
    a_r3_after_done: assert property (@(posedge clk) disable iff (rst)
        $rose(obj_sel) |-> $past(seq_done));

endmodule

// File: rtl/mdc_draw_top.sv
module mdc_draw_top
    import mdc_pkg::*;
#(
    parameter int             X_W    = 9,
    parameter int             Y_W    = 8,
    parameter int             C_W    = 3,
    parameter logic [X_W-1:0] X0     = 9'd100,
    parameter logic [Y_W-1:0] Y0     = 8'd50,
    parameter logic [C_W-1:0] COLOR0 = 3'b100,
    parameter logic [X_W-1:0] X1     = 9'd200,
    parameter logic [Y_W-1:0] Y1     = 8'd150,
    parameter logic [C_W-1:0] COLOR1 = 3'b011
) (
    input  logic           clk,
    input  logic           rst,
    output logic [X_W-1:0] vga_x,
    output logic [Y_W-1:0] vga_y,
    output logic [C_W-1:0] vga_color,
    output logic           vga_wr_en
);

    logic           seq_start, seq_draw, seq_done;
    logic           obj_sel, drawing, finished;
    logic [X_W-1:0] org_x;
    logic [Y_W-1:0] org_y;
    logic [C_W-1:0] obj_color;

    mdc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .seq_done (seq_done),
        .seq_start(seq_start),
        .obj_sel  (obj_sel),
        .drawing  (drawing),
        .finished (finished)
    );

    mdc_obj_select #(
        .X_W(X_W), .Y_W(Y_W), .C_W(C_W),
        .X0(X0), .Y0(Y0), .COLOR0(COLOR0),
        .X1(X1), .Y1(Y1), .COLOR1(COLOR1)
    ) u_sel (
        .sel  (obj_sel),
        .org_x(org_x),
        .org_y(org_y),
        .color(obj_color)
    );

    mdc_ball_seq #(.X_W(X_W), .Y_W(Y_W)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .start(seq_start),
        .org_x(org_x),
        .org_y(org_y),
        .draw (seq_draw),
        .done (seq_done),
        .px   (vga_x),
        .py   (vga_y)
    );

    always_comb begin
        vga_wr_en = seq_draw;
        vga_color = seq_draw ? obj_color : '0;
    end

    // R8: a written pixel always carries a colour
    a_r8_color_on_write: assert property (@(posedge clk) disable iff (rst)
        vga_wr_en |-> (vga_color != '0));

    // R6: no write once the controller has finished
    a_r6_quiet_end: assert property (@(posedge clk) disable iff (rst)
        finished |-> !vga_wr_en);

    // R4: sequencer bursts only while the controller awaits one
    a_r4_draw_in_window: assert property (@(posedge clk) disable iff (rst)
        vga_wr_en |-> drawing);

endmodule

// File: tb/mdc_draw_top_tb.sv
module mdc_draw_top_tb;

    typedef struct packed {
        logic [8:0] x;
        logic [7:0] y;
        logic [2:0] c;
    } pix_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] vga_x;
    logic [7:0] vga_y;
    logic [2:0] vga_color;
    logic       vga_wr_en;

    int   vectors = 0;
    int   miscompares = 0;
    pix_t exp_q[$];
    int   run_len = 0;
    int   bursts = 0;
    int   writes = 0;

    always #2.5 clk = ~clk;

    mdc_draw_top u_dut (
        .clk      (clk),
        .rst      (rst),
        .vga_x    (vga_x),
        .vga_y    (vga_y),
        .vga_color(vga_color),
        .vga_wr_en(vga_wr_en)
    );

    task automatic check(input bit ok, input string req, input string got, input string exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%s expected=%s", req, got, exp);
        end
    endtask

    // Driver: push the plus-shaped ball in row-major order
    task automatic push_ball(input int ox, input int oy, input logic [2:0] c);
        int dx[5] = '{1, 0, 1, 2, 1};
        int dy[5] = '{0, 1, 1, 1, 2};
        for (int i = 0; i < 5; i++) begin
            pix_t p;
            p.x = 9'(ox + dx[i]);
            p.y = 8'(oy + dy[i]);
            p.c = c;
            exp_q.push_back(p);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst) begin
            run_len = 0;
        end else begin
            if (vga_wr_en) begin
                writes++;
                run_len++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", $sformatf("write (%0d,%0d)", vga_x, vga_y), "no write");
                end else begin
                    pix_t e;
                    e = exp_q.pop_front();
                    check(vga_x == e.x && vga_y == e.y && vga_color == e.c,
                          (e.c == 3'b100) ? "R2" : "R3",
                          $sformatf("(%0d,%0d,%b)", vga_x, vga_y, vga_color),
                          $sformatf("(%0d,%0d,%b)", e.x, e.y, e.c));
                end
            end else begin
                check(vga_color == 3'b000, "R8", $sformatf("%b", vga_color), "000");
                if (run_len != 0) begin
                    bursts++;
                    check(run_len == 5, "R4", $sformatf("%0d", run_len), "5");
                end
                run_len = 0;
            end
        end
    end

    task automatic wait_drain(input string req);
        int n = 0;
        while (exp_q.size() != 0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(exp_q.size() == 0, req, $sformatf("%0d left", exp_q.size()), "0 left");
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(vga_wr_en == 1'b0 && vga_color == 3'b000, "R1",
              $sformatf("%b/%b", vga_wr_en, vga_color), "0/000");
        push_ball(100, 50, 3'b100);
        push_ball(200, 150, 3'b011);
        bursts = 0;
        writes = 0;
        rst = 1'b0;
        @(negedge clk);
        check(vga_wr_en == 1'b0 && vga_color == 3'b000, "R1",
              $sformatf("%b/%b", vga_wr_en, vga_color), "0/000");
        wait_drain("R3");
        repeat (3) @(negedge clk);
        check(bursts == 2, "R5", $sformatf("%0d bursts", bursts), "2 bursts");
        // R6: terminal quiet window
        writes = 0;
        repeat (60) @(negedge clk);
        check(writes == 0, "R6", $sformatf("%0d writes", writes), "0 writes");

        // R7: reset in the middle of the first ball
        rst = 1'b1;
        repeat (2) @(negedge clk);
        push_ball(100, 50, 3'b100);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        exp_q.delete();
        repeat (2) @(negedge clk);
        check(vga_wr_en == 1'b0, "R7", $sformatf("%b", vga_wr_en), "0");
        push_ball(100, 50, 3'b100);
        push_ball(200, 150, 3'b011);
        bursts = 0;
        rst = 1'b0;
        wait_drain("R7");
        repeat (3) @(negedge clk);
        check(bursts == 2, "R7", $sformatf("%0d bursts", bursts), "2 bursts");
        writes = 0;
        repeat (20) @(negedge clk);
        check(writes == 0, "R6", $sformatf("%0d writes", writes), "0 writes");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule